// File: doc/BRIEF.md
# Banked Edge-Latching Interrupt Aggregator

This block gathers twenty-four interrupt request lines into three byte-wide banks and presents them to a host over a small byte-wide register bus. Each line is first brought into the clock domain by a two-flop synchronizer. Every line except one is treated as a rising-edge event. When its mask bit is set, the event is held in a status latch. The host acknowledges these events simply by reading the bank's status byte. No separate acknowledge write exists. One line, chosen by a parameter, is level-sensitive. Its status bit mirrors the synchronized input, and a read does not clear it.

A single cascade output goes high whenever any line is both pending in status and enabled in its mask. It drops as soon as nothing enabled remains pending, so an upstream controller that samples it on a rising edge always sees a fresh transition for new work. Edges that arrive while a line is masked are dropped and are never replayed when the line is later enabled.

The register bus is handled by a two-state machine: RB_IDLE and RB_RESP. There are four transitions. RB_IDLE to RB_RESP is taken on a read strobe. RB_RESP to RB_RESP is taken on a back-to-back read strobe. RB_RESP to RB_IDLE is taken when no read is strobed. RB_IDLE to RB_IDLE is taken on idle cycles and on writes. Read data and its valid flag appear on the clock after the strobe.

Top module: `irqagg_top`

## Requirements
- R1: Byte addresses map as follows. Status of bank 0, 1 and 2 sits at 0, 2 and 4. Mask of bank 0, 1 and 2 sits at 1, 3 and 5. A read strobe (bus_valid=1, bus_we=0) returns its byte on bus_rdata with bus_rvalid=1 on the clock after the strobe. bus_rvalid is 0 on the clock after any cycle without a read strobe.
- R2: A mask byte reads back exactly what was last written to it, so single bits can be set or cleared by read-modify-write.
- R3: After a synchronous active-high reset, all mask bytes read 0, all edge status bits read 0 and cascade_irq is 0.
- R4: On an edge-type line whose mask bit is 1, a synchronized sample of 0 followed by a sample of 1 sets that line's status bit. The bit is set three clock edges after the input rises.
- R5: A read of a bank's status byte returns the value from before the clear. On the same edge it clears that bank's latched edge bits. Other banks are not affected.
- R6: The line at index LEVEL_IDX (default 4, which is bank 0 bit 4) shows its synchronized level in status two edges after the input changes. A status read does not clear it.
- R7: An edge that occurs while the line's mask bit is 0 is not latched. Setting the mask bit afterwards leaves status at 0 and cascade_irq low.
- R8: cascade_irq is 1 exactly when some line has both its status bit and its mask bit set. It falls once the last enabled pending bit is cleared.
- R9: If an enabled edge is detected in the same cycle as the read strobe that clears its bank, the bit stays set.
- R10: Writes to status addresses (0, 2, 4) change nothing.
- R11: Line n appears in bank n/8 at bit n%8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Single-cycle register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid on the clock after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| irq_req | input | 24 | Asynchronous interrupt request lines |
| cascade_irq | output | 1 | OR of status AND mask over all lines |

## Verification
An input change that is driven before edge k passes through the two synchronizer flops at edges k and k+1. The edge is latched at k+2, so status and cascade are checked after the third edge. The level line is visible after k+1. Read data, bus_rvalid and the read-clear all take effect at the strobe edge, so they are sampled on the falling edge that follows. The collision test raises the strobe in exactly the cycle in which the detected edge is latched, by counting those same edges.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Register-bus response state machine encoding.
    typedef enum logic {
        RB_IDLE = 1'b0,
        RB_RESP = 1'b1
    } irqagg_rb_state_e;

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank #(
    parameter int BANK_W    = 8,
    parameter int BASE_IDX  = 0,
    parameter int LEVEL_IDX = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] line_sync,
    input  logic              mask_we,
    input  logic [BANK_W-1:0] wdata,
    input  logic              stat_rd,
    output logic [BANK_W-1:0] status,
    output logic [BANK_W-1:0] mask
);

    logic [BANK_W-1:0] mask_q;

    // Mask register: plain storage, reads back what was written.
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= wdata;
        end
    end

    assign mask = mask_q;

    for (genvar i = 0; i < BANK_W; i++) begin : g_bit
        if (BASE_IDX + i == LEVEL_IDX) begin : g_level
            // Level-sensitive line: status is the live synchronized input.
            assign status[i] = line_sync[i];
        end else begin : g_edge
            logic prev_q;
            logic latch_q;
            logic edge_hit;

            assign edge_hit = line_sync[i] & ~prev_q & mask_q[i];

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q  <= 1'b0;
                    latch_q <= 1'b0;
                end else begin
                    prev_q <= line_sync[i];
                    if (edge_hit) begin
                        latch_q <= 1'b1;      // new event wins over a clear
                    end else if (stat_rd) begin
                        latch_q <= 1'b0;
                    end
                end
            end

            assign status[i] = latch_q;
        end
    end

endmodule

// File: rtl/irqagg_regbus.sv
module irqagg_regbus
    import irqagg_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_valid,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [NUM_BANKS*BANK_W-1:0] status_flat,
    input  logic [NUM_BANKS*BANK_W-1:0] mask_flat,
    output logic [NUM_BANKS-1:0]        mask_wr,
    output logic [NUM_BANKS-1:0]        stat_rd,
    output logic [BANK_W-1:0]           bus_rdata,
    output logic                        bus_rvalid
);

    localparam int SEL_W = ADDR_W - 1;

    logic [SEL_W-1:0]   bank_sel;
    logic               is_mask;
    logic               rd_req;
    logic [BANK_W-1:0]  rd_mux;
    logic [BANK_W-1:0]  rdata_q;
    irqagg_rb_state_e   state_q;
    irqagg_rb_state_e   state_d;

    assign bank_sel = bus_addr[ADDR_W-1:1];
    assign is_mask  = bus_addr[0];
    assign rd_req   = bus_valid & ~bus_we;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
        assign mask_wr[b] = bus_valid & bus_we & is_mask & (bank_sel == SEL_W'(b));
        assign stat_rd[b] = rd_req & ~is_mask & (bank_sel == SEL_W'(b));
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel == SEL_W'(b)) begin
                rd_mux = is_mask ? mask_flat[b*BANK_W +: BANK_W]
                                 : status_flat[b*BANK_W +: BANK_W];
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        unique case (state_q)
            RB_IDLE: state_d = rd_req ? RB_RESP : RB_IDLE;
            RB_RESP: state_d = rd_req ? RB_RESP : RB_IDLE;
            default: state_d = RB_IDLE;
        endcase
    end

    // Output process: capture read data on the strobe edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = (state_q == RB_RESP);

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 8,
    parameter int LEVEL_IDX = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_valid,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        bus_rvalid,
    input  logic [23:0] irq_req,
    output logic        cascade_irq
);

    localparam int NUM_LINES = NUM_BANKS * BANK_W;
    localparam int ADDR_W    = $clog2(2 * NUM_BANKS);

    logic [NUM_LINES-1:0] line_sync;
    logic [NUM_LINES-1:0] status_flat;
    logic [NUM_LINES-1:0] mask_flat;
    logic [NUM_BANKS-1:0] mask_wr;
    logic [NUM_BANKS-1:0] stat_rd;

    irqagg_sync #(
        .WIDTH(NUM_LINES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in(irq_req),
        .sync_out(line_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irqagg_bank #(
            .BANK_W   (BANK_W),
            .BASE_IDX (b * BANK_W),
            .LEVEL_IDX(LEVEL_IDX)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .line_sync(line_sync[b*BANK_W +: BANK_W]),
            .mask_we  (mask_wr[b]),
            .wdata    (bus_wdata),
            .stat_rd  (stat_rd[b]),
            .status   (status_flat[b*BANK_W +: BANK_W]),
            .mask     (mask_flat[b*BANK_W +: BANK_W])
        );
    end

    irqagg_regbus #(
        .NUM_BANKS(NUM_BANKS),
        .BANK_W   (BANK_W),
        .ADDR_W   (ADDR_W)
    ) u_regbus (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .status_flat(status_flat),
        .mask_flat  (mask_flat),
        .mask_wr    (mask_wr),
        .stat_rd    (stat_rd),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    assign cascade_irq = |(status_flat & mask_flat);

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
    parameter int NUM_LINES = 24,
    parameter int LEVEL_IDX = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_valid,
    input logic                 bus_we,
    input logic                 bus_rvalid,
    input logic [23:0]          irq_req,
    input logic [NUM_LINES-1:0] status_flat,
    input logic [NUM_LINES-1:0] mask_flat
);

    localparam logic [NUM_LINES-1:0] EDGE_BITS = ~(NUM_LINES'(1) << LEVEL_IDX);

    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    a_r1_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_we) |=> bus_rvalid);

    a_r1_rvalid_only_after_read: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_we) |=> !bus_rvalid);

    a_r3_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask_flat == '0 && (status_flat & EDGE_BITS) == '0));

    a_r7_masked_edge_not_latched: assert property (@(posedge clk) disable iff (rst)
        (($past(~mask_flat & ~status_flat) & status_flat & EDGE_BITS) == '0));

    a_r6_level_tracks_input: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) |-> (status_flat[LEVEL_IDX] == $past(irq_req[LEVEL_IDX], 2)));

endmodule

bind irqagg_top irqagg_checker #(
    .NUM_LINES(NUM_LINES),
    .LEVEL_IDX(LEVEL_IDX)
) u_irqagg_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_we     (bus_we),
    .bus_rvalid (bus_rvalid),
    .irq_req    (irq_req),
    .status_flat(status_flat),
    .mask_flat  (mask_flat)
);

// File: tb/test_irqagg_top.sv
module test_irqagg_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid;
    logic        bus_we;
    logic [2:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic [23:0] irq_req;
    logic        cascade_irq;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    irqagg_top i_irqagg_top (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq_req    (irq_req),
        .cascade_irq(cascade_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d, output logic rv);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        d  = bus_rdata;
        rv = bus_rvalid;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    // Drive a line and wait until any resulting edge is latched (three edges).
    task automatic set_line(input int idx, input logic v);
        @(negedge clk);
        irq_req[idx] = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_expect(input logic [2:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] d;
        logic rv;
        bus_read(a, d, rv);
        check({tag, " rdata"}, 32'(d), 32'(exp));
        check("R1 rvalid after read", 32'(rv), 32'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1; bus_valid = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        irq_req = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        check("R3 cascade low after reset", 32'(cascade_irq), 32'd0);
        check("R1 rvalid idle", 32'(bus_rvalid), 32'd0);
        for (int a = 0; a < 6; a++) read_expect(3'(a), 8'h00, "R3 reset value");
        @(negedge clk);
        check("R1 rvalid drops without read", 32'(bus_rvalid), 32'd0);
    endtask

    task automatic t_mask_rw();
        logic [7:0] d;
        logic rv;
        bus_write(3'd1, 8'hA5);
        bus_write(3'd3, 8'h3C);
        bus_write(3'd5, 8'h81);
        read_expect(3'd1, 8'hA5, "R2 mask bank0");
        read_expect(3'd3, 8'h3C, "R2 mask bank1");
        read_expect(3'd5, 8'h81, "R2 mask bank2");
        bus_read(3'd3, d, rv);
        bus_write(3'd3, d & ~8'h04);
        read_expect(3'd3, 8'h38, "R2 read-modify-write clear");
        for (int a = 1; a < 6; a += 2) bus_write(3'(a), 8'h00);
    endtask

    task automatic t_edge_latch();
        bus_write(3'd3, 8'h04);   // line 10
        bus_write(3'd5, 8'h02);   // line 17
        set_line(10, 1'b1);
        check("R4 R8 cascade after enabled edge", 32'(cascade_irq), 32'd1);
        set_line(17, 1'b1);
        read_expect(3'd0, 8'h00, "R5 bank0 read");
        read_expect(3'd2, 8'h04, "R11 line10 in bank1 bit2");
        read_expect(3'd4, 8'h02, "R5 R11 bank2 kept after other reads");
        check("R8 cascade drops after clear", 32'(cascade_irq), 32'd0);
        read_expect(3'd2, 8'h00, "R5 bank1 cleared");
        read_expect(3'd4, 8'h00, "R5 bank2 cleared");
        set_line(10, 1'b0);
        set_line(17, 1'b0);
        check("R4 falling edge not latched", 32'(cascade_irq), 32'd0);
    endtask

    task automatic t_masked_drop();
        set_line(12, 1'b1);        // bank1 mask is 0x04, bit 4 is off
        bus_write(3'd3, 8'h14);
        repeat (2) @(negedge clk);
        check("R7 cascade stays low", 32'(cascade_irq), 32'd0);
        read_expect(3'd2, 8'h00, "R7 masked edge dropped");
        set_line(12, 1'b0);
        bus_write(3'd3, 8'h00);
        bus_write(3'd5, 8'h00);
    endtask

    task automatic t_level();
        bus_write(3'd1, 8'h10);   // line 4 is the level line
        @(negedge clk);
        irq_req[4] = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 level visible after two edges", 32'(cascade_irq), 32'd1);
        read_expect(3'd0, 8'h10, "R6 level status");
        read_expect(3'd0, 8'h10, "R6 level not cleared by read");
        @(negedge clk);
        irq_req[4] = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 R8 cascade follows level low", 32'(cascade_irq), 32'd0);
        read_expect(3'd0, 8'h00, "R6 level low");
    endtask

    task automatic t_status_write();
        bus_write(3'd0, 8'hFF);
        bus_write(3'd2, 8'hFF);
        bus_write(3'd4, 8'hFF);
        check("R10 cascade after status write", 32'(cascade_irq), 32'd0);
        read_expect(3'd0, 8'h00, "R10 status0 write ignored");
        read_expect(3'd2, 8'h00, "R10 status1 write ignored");
        read_expect(3'd4, 8'h00, "R10 status2 write ignored");
        read_expect(3'd1, 8'h10, "R10 mask0 untouched");
    endtask

    task automatic t_collision();
        logic [7:0] d;
        bus_write(3'd1, 8'h03);
        set_line(0, 1'b1);         // bit 0 latched
        @(negedge clk);
        irq_req[1] = 1'b1;         // edge k: stage1, k+1: stage2, k+2: latch
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = 3'd0;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
        check("R5 R9 pre-clear data", 32'(d), 32'h01);
        check("R9 cascade held by new edge", 32'(cascade_irq), 32'd1);
        read_expect(3'd0, 8'h02, "R9 colliding edge kept");
        read_expect(3'd0, 8'h00, "R9 cleared afterwards");
        set_line(0, 1'b0);
        set_line(1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_mask_rw();
        t_edge_latch();
        t_masked_drop();
        t_level();
        t_status_write();
        t_collision();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule